// File: doc/BRIEF.md
# Arithmetic Status Flags Register

This block pairs an integer add/subtract unit with the 32-bit status word that records what that unit last did. A caller presents two operands, picks one of four arithmetic operations and one of three operand sizes. The truncated result appears at the output in the same cycle. When the flag-write enable is high, the six arithmetic status bits are captured at the next rising clock edge.

The same status word also holds a set of control bits. A separate load strobe writes them. Inside the block they are only stored and read back, and they never change the arithmetic. Reserved positions are tied to constants, so software always sees a well-formed word. Chained wide arithmetic works by issuing the low part with a plain add or subtract, then each higher part with the carry-consuming variant.

Top module: `arith_status_reg`

## Requirements
- R1: After a synchronous active-high reset the status word reads 0x0000_0002.
- R2: Bit 1 of the status word always reads 1. Bits 3, 5, 15 and 31:22 always read 0, whatever is written through either port.
- R3: op_sel encodes 0 add, 1 add-with-carry, 2 subtract, 3 subtract-with-borrow. size_sel encodes 0 as 8 bits, 1 as 16 bits, and 2 or 3 as 32 bits. The result is combinational, and is the operation on the operands truncated to the selected size, with all bits above that size zero.
- R4: Status bit 0 (carry) is set when an add carries out of the top bit of the selected size, or when a subtract needs a borrow into it.
- R5: Add-with-carry adds stored bit 0 as an extra 1. Subtract-with-borrow subtracts it as an extra 1. Plain add and subtract ignore it.
- R6: Status bit 2 (parity) is set when result bits 7:0 hold an even number of ones, for every size.
- R7: Status bit 4 (adjust) is set on a carry out of, or a borrow into, operand bit 3. The stored carry-in counts.
- R8: Status bit 6 (zero) is set when the truncated result is zero. Status bit 7 (sign) equals the top result bit of the selected size.
- R9: Status bit 11 (overflow) is set when the signed two's complement result does not fit the selected size.
- R10: With flag_we high, bits 0, 2, 4, 6, 7 and 11 take the values of the current cycle's operation at the rising edge. With flag_we low they keep their previous values.
- R11: With ctl_we high, status bits 8, 9, 10, 12, 13, 14 and 16 to 21 load the same bit positions of ctl_wdata at the rising edge, including the 2-bit field at 13:12 unchanged. Otherwise they hold. They never affect the result or the arithmetic bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| opa | input | 32 | First operand |
| opb | input | 32 | Second operand |
| op_sel | input | 2 | Operation select |
| size_sel | input | 2 | Operand size select |
| flag_we | input | 1 | Capture arithmetic status bits |
| ctl_we | input | 1 | Load control status bits |
| ctl_wdata | input | 32 | Control bit values, in status-word positions |
| result | output | 32 | Truncated arithmetic result |
| flags | output | 32 | Status word |

## Verification
On every cycle, assertions check that the reserved bits keep their constants, that arithmetic bits hold while flag_we is low, and that control bits either hold or take the written value. They also check that the stored parity and zero bits agree with the result the unit produced in the previous cycle. Carry, adjust, overflow and sign across the three sizes can only be shown by the bench's reference model. The same goes for carry chaining through the carry-consuming operations and for simultaneous writes on both ports. The bench compares all of these on every clock, over directed corner operands and a long pseudo-random run.

// File: rtl/status_pkg.sv
package status_pkg;

    localparam int XLEN     = 32;
    localparam int STATUS_W = 32;
    localparam int NIB_W    = 4;

    typedef enum logic [1:0] {
        OP_ADD = 2'd0,
        OP_ADC = 2'd1,
        OP_SUB = 2'd2,
        OP_SBB = 2'd3
    } op_e;

    typedef enum logic [1:0] {
        SZ_BYTE  = 2'd0,
        SZ_HALF  = 2'd1,
        SZ_WORD  = 2'd2,
        SZ_WORD2 = 2'd3
    } size_e;

    localparam int SB_CARRY  = 0;
    localparam int SB_PARITY = 2;
    localparam int SB_ADJUST = 4;
    localparam int SB_ZERO   = 6;
    localparam int SB_SIGN   = 7;
    localparam int SB_OVF    = 11;

    localparam logic [STATUS_W-1:0] ARITH_BITS = 32'h0000_08D5;
    localparam logic [STATUS_W-1:0] CTL_BITS   = 32'h003F_7700;
    localparam logic [STATUS_W-1:0] ONE_BITS   = 32'h0000_0002;

    typedef struct packed {
        logic carry;
        logic parity;
        logic adjust;
        logic zero;
        logic sign;
        logic overflow;
    } arith_flags_t;

    function automatic logic [XLEN-1:0] size_mask(input size_e s);
        case (s)
            SZ_BYTE: size_mask = XLEN'(8'hFF);
            SZ_HALF: size_mask = XLEN'(16'hFFFF);
            default: size_mask = '1;
        endcase
    endfunction

    function automatic logic top_bit(input logic [XLEN:0] v, input size_e s);
        case (s)
            SZ_BYTE: top_bit = v[7];
            SZ_HALF: top_bit = v[15];
            default: top_bit = v[31];
        endcase
    endfunction

    function automatic logic out_bit(input logic [XLEN+1:0] v, input size_e s);
        case (s)
            SZ_BYTE: out_bit = v[8];
            SZ_HALF: out_bit = v[16];
            default: out_bit = v[32];
        endcase
    endfunction

    function automatic logic [STATUS_W-1:0] place_arith(input arith_flags_t f);
        logic [STATUS_W-1:0] w;
        w            = '0;
        w[SB_CARRY]  = f.carry;
        w[SB_PARITY] = f.parity;
        w[SB_ADJUST] = f.adjust;
        w[SB_ZERO]   = f.zero;
        w[SB_SIGN]   = f.sign;
        w[SB_OVF]    = f.overflow;
        return w;
    endfunction

endpackage

// File: rtl/status_addsub.sv
module status_addsub
    import status_pkg::*;
(
    input  logic [XLEN-1:0] a_i,
    input  logic [XLEN-1:0] b_i,
    input  op_e             op_i,
    input  size_e           size_i,
    input  logic            carry_i,
    output logic [XLEN-1:0] res_o,
    output arith_flags_t    flags_o
);

    localparam int EXT_W = XLEN + 2;

    logic [XLEN-1:0]  mask;
    logic [XLEN-1:0]  am, bm;
    logic             cin, is_sub;
    logic [EXT_W-1:0] ext;
    logic [NIB_W+1:0] nib;
    logic             sa, sb, sr;

    always_comb begin
        mask   = size_mask(size_i);
        am     = a_i & mask;
        bm     = b_i & mask;
        is_sub = (op_i == OP_SUB) || (op_i == OP_SBB);
        cin    = carry_i && ((op_i == OP_ADC) || (op_i == OP_SBB));
        if (is_sub) begin
            ext = {2'b00, am} - {2'b00, bm} - EXT_W'(cin);
            nib = {2'b00, am[NIB_W-1:0]} - {2'b00, bm[NIB_W-1:0]} - (NIB_W+2)'(cin);
        end else begin
            ext = {2'b00, am} + {2'b00, bm} + EXT_W'(cin);
            nib = {2'b00, am[NIB_W-1:0]} + {2'b00, bm[NIB_W-1:0]} + (NIB_W+2)'(cin);
        end
        res_o = ext[XLEN-1:0] & mask;
        sa    = top_bit({1'b0, am}, size_i);
        sb    = top_bit({1'b0, bm}, size_i);
        sr    = top_bit({1'b0, res_o}, size_i);

        flags_o.carry    = is_sub ? ext[EXT_W-1] : out_bit(ext, size_i);
        flags_o.adjust   = nib[NIB_W];
        flags_o.parity   = ~^res_o[7:0];
        flags_o.zero     = (res_o == '0);
        flags_o.sign     = sr;
        flags_o.overflow = is_sub ? ((sa != sb) && (sr != sa))
                                  : ((sa == sb) && (sr != sa));
    end

endmodule

// File: rtl/status_word.sv
module status_word
    import status_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                arith_we_i,
    input  arith_flags_t        arith_i,
    input  logic                ctl_we_i,
    input  logic [STATUS_W-1:0] ctl_i,
    output logic [STATUS_W-1:0] word_o
);

    logic [STATUS_W-1:0] arith_vec;

    always_comb arith_vec = place_arith(arith_i);

    for (genvar i = 0; i < STATUS_W; i++) begin : g_bit
        if (ARITH_BITS[i]) begin : g_arith
            logic q;
            always_ff @(posedge clk) begin
                if (rst)             q <= 1'b0;
                else if (arith_we_i) q <= arith_vec[i];
            end
            assign word_o[i] = q;
        end else if (CTL_BITS[i]) begin : g_ctl
            logic q;
            always_ff @(posedge clk) begin
                if (rst)           q <= 1'b0;
                else if (ctl_we_i) q <= ctl_i[i];
            end
            assign word_o[i] = q;
        end else begin : g_fixed
            assign word_o[i] = ONE_BITS[i];
        end
    end

    a_r2_reserved_fixed: assert property (@(posedge clk) disable iff (rst)
        (word_o & ~(ARITH_BITS | CTL_BITS)) == ONE_BITS);

    a_r10_arith_hold: assert property (@(posedge clk) disable iff (rst)
        !arith_we_i |=> ((word_o & ARITH_BITS) == ($past(word_o) & ARITH_BITS)));

    a_r11_ctl_hold: assert property (@(posedge clk) disable iff (rst)
        !ctl_we_i |=> ((word_o & CTL_BITS) == ($past(word_o) & CTL_BITS)));

    a_r11_ctl_load: assert property (@(posedge clk) disable iff (rst)
        ctl_we_i |=> ((word_o & CTL_BITS) == ($past(ctl_i) & CTL_BITS)));

endmodule

// File: rtl/arith_status_reg.sv
module arith_status_reg
    import status_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic [XLEN-1:0] opa,
    input  logic [XLEN-1:0] opb,
    input  logic [1:0]      op_sel,
    input  logic [1:0]      size_sel,
    input  logic            flag_we,
    input  logic            ctl_we,
    input  logic [31:0]     ctl_wdata,
    output logic [XLEN-1:0] result,
    output logic [31:0]     flags
);

    arith_flags_t new_flags;

    status_addsub u_addsub (
        .a_i     (opa),
        .b_i     (opb),
        .op_i    (op_e'(op_sel)),
        .size_i  (size_e'(size_sel)),
        .carry_i (flags[SB_CARRY]),
        .res_o   (result),
        .flags_o (new_flags)
    );

    status_word u_word (
        .clk        (clk),
        .rst        (rst),
        .arith_we_i (flag_we),
        .arith_i    (new_flags),
        .ctl_we_i   (ctl_we),
        .ctl_i      (ctl_wdata),
        .word_o     (flags)
    );

    a_r6_parity_tracks: assert property (@(posedge clk) disable iff (rst)
        flag_we |=> (flags[SB_PARITY] == ~^$past(result[7:0])));

    a_r8_zero_tracks: assert property (@(posedge clk) disable iff (rst)
        flag_we |=> (flags[SB_ZERO] == ($past(result) == '0)));

endmodule

// File: tb/arith_status_reg_tb_top.sv
module arith_status_reg_tb_top;

    logic        clk = 1'b0;
    logic        rst;
    logic [31:0] opa, opb, ctl_wdata;
    logic [1:0]  op_sel, size_sel;
    logic        flag_we, ctl_we;
    logic [31:0] result, flags;

    int checks = 0;
    int errors = 0;
    logic [31:0] m_flags;
    logic [31:0] m_res;
    logic [31:0] m_next;

    always #5 clk = ~clk;

    arith_status_reg dut_i (
        .clk(clk), .rst(rst), .opa(opa), .opb(opb), .op_sel(op_sel),
        .size_sel(size_sel), .flag_we(flag_we), .ctl_we(ctl_we),
        .ctl_wdata(ctl_wdata), .result(result), .flags(flags)
    );

    task automatic cmp(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Behavioural reference: integer arithmetic, computes result and new arithmetic bits.
    task automatic model(input logic [31:0] a, input logic [31:0] b, input int op,
                         input int sz, input bit cf_in,
                         output logic [31:0] r, output logic [31:0] fl);
        longint w, lim, ua, ub, c, full, sa, sb, sr;
        int ones;
        bit sub;
        w    = (sz == 0) ? 8 : (sz == 1) ? 16 : 32;
        lim  = longint'(1) << w;
        ua   = longint'(a) % lim;
        ub   = longint'(b) % lim;
        sub  = (op >= 2);
        c    = ((op == 1 || op == 3) && cf_in) ? 1 : 0;
        full = sub ? ua - ub - c : ua + ub + c;
        r    = 32'(((full % lim) + lim) % lim);
        fl   = 32'h0;
        fl[0] = sub ? (ua < ub + c) : (full >= lim);
        ones = $countones(r[7:0]);
        fl[2] = (ones % 2 == 0);
        fl[4] = sub ? ((ua % 16) < (ub % 16) + c) : ((ua % 16) + (ub % 16) + c > 15);
        fl[6] = (r == 0);
        fl[7] = r[w-1];
        sa = (ua >= lim / 2) ? ua - lim : ua;
        sb = (ub >= lim / 2) ? ub - lim : ub;
        sr = sub ? sa - sb - c : sa + sb + c;
        fl[11] = (sr >= lim / 2) || (sr < -(lim / 2));
    endtask

    task automatic step(input string tag, input logic [31:0] a, input logic [31:0] b,
                        input int op, input int sz, input bit fwe,
                        input bit cwe, input logic [31:0] cdata);
        logic [31:0] fl;
        @(negedge clk);
        opa = a; opb = b; op_sel = 2'(op); size_sel = 2'(sz);
        flag_we = fwe; ctl_we = cwe; ctl_wdata = cdata;
        #1;
        model(a, b, op, sz, m_flags[0], m_res, fl);
        cmp({tag, " R3 result"}, result, m_res);
        m_next = m_flags;
        if (fwe) m_next = (m_next & ~32'h0000_08D5) | fl;
        if (cwe) m_next = (m_next & ~32'h003F_7700) | (cdata & 32'h003F_7700);
        @(posedge clk);
        m_flags = m_next;
        #1;
        cmp({tag, " R4 carry"},    {31'b0, flags[0]},  {31'b0, m_flags[0]});
        cmp({tag, " R6 parity"},   {31'b0, flags[2]},  {31'b0, m_flags[2]});
        cmp({tag, " R7 adjust"},   {31'b0, flags[4]},  {31'b0, m_flags[4]});
        cmp({tag, " R8 zero/sign"}, {30'b0, flags[7:6]}, {30'b0, m_flags[7:6]});
        cmp({tag, " R9 overflow"}, {31'b0, flags[11]}, {31'b0, m_flags[11]});
        cmp({tag, " R11 control"}, flags & 32'h003F_7700, m_flags & 32'h003F_7700);
        cmp({tag, " R2 reserved"}, flags & ~32'h003F_7FD5, 32'h0000_0002);
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst = 1'b1; opa = '0; opb = '0; op_sel = '0; size_sel = '0;
        flag_we = 1'b0; ctl_we = 1'b0; ctl_wdata = '0;
        repeat (2) @(posedge clk);
        #1;
        cmp("R1 reset word", flags, 32'h0000_0002);
        @(negedge clk);
        rst = 1'b0;
        m_flags = 32'h0000_0002;

        // R8/R9/R7: signed overflow at byte size, nibble carry
        step("R9 byte 7F+01", 32'h7F, 32'h01, 0, 0, 1, 0, 0);
        // R4/R8: carry out and zero at byte size, upper bits ignored
        step("R4 byte FF+01", 32'hABCD_12FF, 32'h01, 0, 0, 1, 0, 0);
        // R5: add-with-carry consumes the stored carry
        step("R5 adc chain", 32'h10, 32'h20, 1, 0, 1, 0, 0);
        // R4: borrow at half size
        step("R4 half 0-1", 32'h0, 32'h1, 2, 1, 1, 0, 0);
        // R5: subtract-with-borrow with stored borrow set
        step("R5 sbb chain", 32'h8000, 32'h0, 3, 1, 1, 0, 0);
        // R5: plain subtract ignores stored carry
        step("R5 sub ignores", 32'h5, 32'h5, 2, 2, 1, 0, 0);
        // R9: word overflow on subtract
        step("R9 word sub", 32'h8000_0000, 32'h1, 2, 2, 1, 0, 0);
        // R3: size code 3 behaves as 32-bit
        step("R3 size3", 32'hFFFF_FFFF, 32'h1, 0, 3, 1, 0, 0);
        // R10: flag_we low holds arithmetic bits
        step("R10 hold", 32'h7F, 32'h7F, 0, 0, 0, 0, 0);
        // R11/R2: write all ones to control port, reserved unchanged
        step("R11 ctl ones", 32'h1, 32'h1, 0, 2, 0, 1, 32'hFFFF_FFFF);
        // R11: privilege field value 2 stored unchanged, both ports at once
        step("R11 iopl", 32'h3, 32'h4, 2, 0, 1, 1, 32'h0000_2000);
        step("R11 ctl hold", 32'h0, 32'h0, 0, 0, 1, 0, 32'hFFFF_FFFF);

        for (int i = 0; i < 400; i++) begin
            logic [31:0] ra, rb, rc;
            int ro, rs;
            ra = $urandom; rb = $urandom; rc = $urandom;
            if (i % 5 == 0) rb = ra;
            ro = $urandom_range(0, 3);
            rs = $urandom_range(0, 3);
            step("R10 random", ra, rb, ro, rs, ($urandom_range(0, 3) != 0),
                 ($urandom_range(0, 4) == 0), rc);
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule